// File: doc/BRIEF.md
# Single-Accumulator Processor with Index Register

This block is a small multicycle processor built around one 16-bit accumulator, a 12-bit program counter and a 12-bit index register. Instructions and data share one word-addressed memory, reached through a single synchronous port. The port's read data appears one clock after the address is presented, and a write happens on the clock edge that ends a cycle with the write enable high.

Each 16-bit instruction word carries a 4-bit opcode in bits [15:12] and a 12-bit address or immediate field in bits [11:0]. The instruction set covers several groups:
- load, store, add and subtract on the accumulator;
- an unconditional jump and a jump taken when the accumulator is not negative;
- one-bit shifts;
- a load and a store of only the address field of a memory word, which supports self-modifying programs;
- indexed load, add and store;
- index-register load, store and add-immediate;
- a branch that tests the index register for zero and otherwise increments it;
- halt.

After reset the processor runs from address 0 until it decodes a halt. It then raises `halted` and stays idle.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and after its release, PC, AC and IX start at zero and `halted` is low. Memory address 0 is fetched first, in the second clock cycle after `rst_n` rises.
- R2: An instruction word is opcode [15:12] plus field [11:0]. Each instruction takes two cycles (fetch, decode), or three when it reads a memory operand. A store drives its write in the second cycle. The address-field store drives its write in the third cycle. PC advances by one unless a branch is taken.
- R3: Opcode 1 loads AC from M[x]. Opcode 2 writes AC to M[x]. Opcode 3 adds M[x] to AC and opcode 4 subtracts it, both modulo 2^16.
- R4: Opcode 5 sets PC to x. Opcode 6 sets PC to x only when AC bit 15 is 0.
- R5: Opcode 7 sets AC to bits [11:0] of M[x], zero-extended. Opcode 8 replaces bits [11:0] of M[x] with AC[11:0] and keeps bits [15:12].
- R6: Opcodes 9 (load), 10 (add) and 11 (store) use the effective address (x + IX) mod 4096.
- R7: Opcode 12 sets PC to x when IX is zero. Otherwise it adds one to IX and continues with the next instruction.
- R8: Opcode 13 loads IX from bits [11:0] of M[x]. Opcode 14 writes IX to M[x], sign-extended from bit 11 to 16 bits.
- R9: Opcode 15 adds the field to IX modulo 4096 and leaves AC unchanged.
- R10: Opcode 0 with field bits [1:0] = 01 shifts AC left by one. With 10 it shifts AC right by one, arithmetically (bit 15 is kept).
- R11: Opcode 0 with field bits [1:0] = 00 or 11 halts. `halted` rises two cycles after the halt word's fetch cycle, stays high until reset, and no memory write occurs while it is high.
- R12: A three-element vector addition C[i] = A[i] + B[i] gives the same results whether written with self-modifying address fields or with the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 12 | Memory word address |
| mem_we | output | 1 | Memory write enable for the current cycle |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data for the address of the previous cycle |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Every memory write has a fixed due cycle, counted from the release of reset:
- the first fetch happens at count 2;
- a store writes one cycle after its fetch cycle;
- an address-field store writes two cycles after its fetch cycle;
- `halted` is first seen two cycles after the halt word's fetch cycle.

The bench runs its own instruction-level model of each program. That model steps a cycle counter by two or three per instruction and queues each expected write with its data and due cycle. A monitor samples at the falling clock edge, pops the queue on every write, and compares address, data and cycle count. Results that are never written through the port, such as branches not taken, are checked afterwards in the memory image.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_MISC  = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_JUMP  = 4'h5,
    OP_JGE   = 4'h6,
    OP_LDFLD = 4'h7,
    OP_STFLD = 4'h8,
    OP_LDX   = 4'h9,
    OP_ADDX  = 4'hA,
    OP_STX   = 4'hB,
    OP_JZI   = 4'hC,
    OP_LDI   = 4'hD,
    OP_STI   = 4'hE,
    OP_INCI  = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_DEC,
    ST_EXEC,
    ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_FIELD,
    ALU_SHL,
    ALU_SHR
  } alu_op_e;

  typedef struct packed {
    logic    rd_op;
    logic    wr_dec;
    logic    wr_ix;
    logic    wr_late;
    logic    indexed;
    logic    jump;
    logic    jge;
    logic    jzi;
    logic    ix_load;
    logic    ix_imm;
    logic    shift;
    logic    halt;
    logic    ac_we;
    alu_op_e alu;
  } ctl_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_o_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_o_n = stage2_q;

endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  opcode_e    op,
  input  logic [1:0] sub,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '0;
    ctl.alu = ALU_PASS;
    unique case (op)
      OP_MISC: begin
        if (sub == 2'b01) begin
          ctl.shift = 1'b1;
          ctl.alu   = ALU_SHL;
        end else if (sub == 2'b10) begin
          ctl.shift = 1'b1;
          ctl.alu   = ALU_SHR;
        end else begin
          ctl.halt = 1'b1;
        end
      end
      OP_LOAD:  begin ctl.rd_op = 1'b1; ctl.ac_we = 1'b1; end
      OP_ADD:   begin ctl.rd_op = 1'b1; ctl.ac_we = 1'b1; ctl.alu = ALU_ADD; end
      OP_SUB:   begin ctl.rd_op = 1'b1; ctl.ac_we = 1'b1; ctl.alu = ALU_SUB; end
      OP_STORE: ctl.wr_dec = 1'b1;
      OP_JUMP:  ctl.jump = 1'b1;
      OP_JGE:   ctl.jge = 1'b1;
      OP_LDFLD: begin ctl.rd_op = 1'b1; ctl.ac_we = 1'b1; ctl.alu = ALU_FIELD; end
      OP_STFLD: begin ctl.rd_op = 1'b1; ctl.wr_late = 1'b1; end
      OP_LDX:   begin ctl.rd_op = 1'b1; ctl.ac_we = 1'b1; ctl.indexed = 1'b1; end
      OP_ADDX:  begin ctl.rd_op = 1'b1; ctl.ac_we = 1'b1; ctl.indexed = 1'b1; ctl.alu = ALU_ADD; end
      OP_STX:   begin ctl.wr_dec = 1'b1; ctl.indexed = 1'b1; end
      OP_JZI:   ctl.jzi = 1'b1;
      OP_LDI:   begin ctl.rd_op = 1'b1; ctl.ix_load = 1'b1; end
      OP_STI:   begin ctl.wr_dec = 1'b1; ctl.wr_ix = 1'b1; end
      OP_INCI:  ctl.ix_imm = 1'b1;
      default:  ctl.halt = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_FIELD: y = {{(DW-AW){1'b0}}, b[AW-1:0]};
      ALU_SHL:   y = {a[DW-2:0], 1'b0};
      ALU_SHR:   y = {a[DW-1], a[DW-1:1]};
      default:   y = b;
    endcase
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  localparam int               EXT   = DW - AW;
  localparam logic [AW-1:0]    ONE_A = AW'(1);

  logic    rst_i_n;
  state_e  state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, ix_q, ix_d, ea_q, ea_dec;
  logic [DW-1:0] ac_q, ac_d, alu_y;
  alu_op_e exec_alu_q, alu_sel;
  logic    exec_ac_q, exec_ix_q, exec_wl_q;
  ctl_t    ctl;
  logic [AW-1:0] field;
  logic    dec_en;

  acc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_o_n(rst_i_n));

  assign field = mem_rdata[AW-1:0];

  acc_decode u_dec (
    .op  (opcode_e'(mem_rdata[DW-1:AW])),
    .sub (field[1:0]),
    .ctl (ctl)
  );

  assign alu_sel = (state_q == ST_DEC) ? ctl.alu : exec_alu_q;

  acc_alu #(.DW(DW), .AW(AW)) u_alu (
    .op (alu_sel),
    .a  (ac_q),
    .b  (mem_rdata),
    .y  (alu_y)
  );

  assign ea_dec = field + (ctl.indexed ? ix_q : '0);
  assign dec_en = (state_q == ST_DEC);
  assign halted = (state_q == ST_HALT);

  // next-state and memory port
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ac_d      = ac_q;
    ix_d      = ix_q;
    mem_addr  = pc_q;
    mem_we    = 1'b0;
    mem_wdata = ac_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_DEC;
      ST_DEC: begin
        state_d = ST_FETCH;
        pc_d    = pc_q + ONE_A;
        if (ctl.halt) begin
          state_d = ST_HALT;
          pc_d    = pc_q;
        end
        if (ctl.rd_op) begin
          mem_addr = ea_dec;
          state_d  = ST_EXEC;
        end
        if (ctl.wr_dec) begin
          mem_addr  = ea_dec;
          mem_we    = 1'b1;
          mem_wdata = ctl.wr_ix ? {{EXT{ix_q[AW-1]}}, ix_q} : ac_q;
        end
        if (ctl.jump || (ctl.jge && !ac_q[DW-1])) pc_d = field;
        if (ctl.jzi) begin
          if (ix_q == '0) pc_d = field;
          else            ix_d = ix_q + ONE_A;
        end
        if (ctl.ix_imm) ix_d = ix_q + field;
        if (ctl.shift)  ac_d = alu_y;
      end
      ST_EXEC: begin
        state_d  = ST_FETCH;
        mem_addr = ea_q;
        if (exec_ac_q) ac_d = alu_y;
        if (exec_ix_q) ix_d = mem_rdata[AW-1:0];
        if (exec_wl_q) begin
          mem_we    = 1'b1;
          mem_wdata = {mem_rdata[DW-1:AW], ac_q[AW-1:0]};
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  // architectural registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ac_q    <= '0;
      ix_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ac_q    <= ac_d;
      ix_q    <= ix_d;
    end
  end

  // operand-phase control, enabled in decode
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ea_q       <= '0;
      exec_alu_q <= ALU_PASS;
      exec_ac_q  <= 1'b0;
      exec_ix_q  <= 1'b0;
      exec_wl_q  <= 1'b0;
    end else if (dec_en) begin
      ea_q       <= ea_dec;
      exec_alu_q <= ctl.alu;
      exec_ac_q  <= ctl.ac_we;
      exec_ix_q  <= ctl.ix_load;
      exec_wl_q  <= ctl.wr_late;
    end
  end

  // R11: once halted, stays halted
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    halted |=> halted);

  // R11: no write while halted
  p_quiet_halt_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    halted |-> !mem_we);

  // R2: PC steps by one when no branch is decoded
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dec_en && !ctl.jump && !ctl.jge && !ctl.jzi && !ctl.halt)
      |=> (pc_q == $past(pc_q) + ONE_A));

  // R2: operand phase only follows decode
  p_exec_after_dec_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_EXEC) |-> ($past(state_q) == ST_DEC));

  // R9: index add-immediate leaves AC alone
  p_inci_keeps_ac_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dec_en && ctl.ix_imm) |=> $stable(ac_q));

  // R8: IX changes only through the index instructions
  p_ix_hold_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dec_en && !ctl.jzi && !ctl.ix_imm) |=> $stable(ix_q));

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int MW = 8;
  localparam int MD = 1 << MW;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            c;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          halted;

  logic          ld_en;
  logic [MW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic [DW-1:0] mem  [MD];
  logic [DW-1:0] img  [MD];
  logic [DW-1:0] rmem [MD];
  int            cnt;
  int            nchk;
  int            nerr;
  logic          mon_on;
  exp_t          exp_q[$];

  always #2.5 clk = ~clk;

  acc_cpu #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[MW-1:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[MW-1:0]];
  end

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else        cnt <= cnt + 1;
  end

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] f);
    return {op, f};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] expv);
    nchk++;
    if (got !== expv) begin
      nerr++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, expv);
    end
  endtask

  task automatic push_w(input logic [AW-1:0] a, input logic [DW-1:0] d, input int c,
                        input string tag);
    exp_t e;
    e.a = a; e.d = d; e.c = c; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // instruction-level model: fetch of first word at count 2
  task automatic ref_run(output int hc);
    logic [AW-1:0] rpc, rix, f, eix;
    logic [DW-1:0] rac, w;
    int cyc;
    for (int i = 0; i < MD; i++) rmem[i] = img[i];
    rpc = '0; rix = '0; rac = '0; cyc = 2; hc = -1;
    for (int n = 0; n < 4000; n++) begin
      w = rmem[rpc[MW-1:0]];
      f = w[AW-1:0];
      eix = f + rix;
      if (w[15:12] == 4'h0 && (f[1] == f[0])) begin
        hc = cyc + 2;
        break;
      end
      rpc = rpc + 1'b1;
      unique case (w[15:12])
        4'h0: begin rac = f[0] ? {rac[14:0], 1'b0} : {rac[15], rac[15:1]}; cyc += 2; end
        4'h1: begin rac = rmem[f[MW-1:0]]; cyc += 3; end
        4'h2: begin rmem[f[MW-1:0]] = rac; push_w(f, rac, cyc + 1, "R3"); cyc += 2; end
        4'h3: begin rac = rac + rmem[f[MW-1:0]]; cyc += 3; end
        4'h4: begin rac = rac - rmem[f[MW-1:0]]; cyc += 3; end
        4'h5: begin rpc = f; cyc += 2; end
        4'h6: begin if (!rac[15]) rpc = f; cyc += 2; end
        4'h7: begin rac = {4'h0, rmem[f[MW-1:0]][11:0]}; cyc += 3; end
        4'h8: begin
          rmem[f[MW-1:0]] = {rmem[f[MW-1:0]][15:12], rac[11:0]};
          push_w(f, rmem[f[MW-1:0]], cyc + 2, "R5"); cyc += 3;
        end
        4'h9: begin rac = rmem[eix[MW-1:0]]; cyc += 3; end
        4'hA: begin rac = rac + rmem[eix[MW-1:0]]; cyc += 3; end
        4'hB: begin rmem[eix[MW-1:0]] = rac; push_w(eix, rac, cyc + 1, "R6"); cyc += 2; end
        4'hC: begin if (rix == '0) rpc = f; else rix = rix + 1'b1; cyc += 2; end
        4'hD: begin rix = rmem[f[MW-1:0]][11:0]; cyc += 3; end
        4'hE: begin
          rmem[f[MW-1:0]] = {{4{rix[11]}}, rix};
          push_w(f, {{4{rix[11]}}, rix}, cyc + 1, "R8"); cyc += 2;
        end
        default: begin rix = rix + f; cyc += 2; end
      endcase
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < MD; i++) img[i] = '0;
  endtask

  task automatic vec_data();
    img[8'h40] = 16'hFFFD;  img[8'h41] = 16'h0001;
    img[8'h50] = 16'h0003;  img[8'h51] = 16'h7FFF;  img[8'h52] = 16'hFFF0;
    img[8'h60] = 16'h0004;  img[8'h61] = 16'h0002;  img[8'h62] = 16'h0011;
  endtask

  task automatic run_prog(input string nm);
    int hc;
    int guard;
    logic held;
    exp_q.delete();
    ref_run(hc);
    rst_n  = 1'b0;
    mon_on = 1'b0;
    for (int i = 0; i < MD; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = MW'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    chk("R1", {nm, " reset addr"}, 32'(mem_addr), 32'h0);
    chk("R1", {nm, " reset halted"}, 32'(halted), 32'h0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    guard  = 0;
    while (!halted && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk("R11", {nm, " halt cycle"}, 32'(cnt), 32'(hc));
    held = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (!halted) held = 1'b0;
    end
    chk("R11", {nm, " halted held"}, 32'(held), 32'h1);
    chk("R2", {nm, " writes left"}, 32'(exp_q.size()), 32'h0);
    mon_on = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    nchk = 0; nerr = 0; mon_on = 1'b0;

    fork
      begin : monitor
        exp_t e;
        forever begin
          @(negedge clk);
          if (mon_on && rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
              chk("R11", "unexpected write", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
              e = exp_q.pop_front();
              chk(e.tag, "write addr", 32'(mem_addr), 32'(e.a));
              chk(e.tag, "write data", 32'(mem_wdata), 32'(e.d));
              chk("R2", "write cycle", 32'(cnt), 32'(e.c));
            end
          end
        end
      end
      begin : watchdog
        #400us;
        nerr++;
        $display("FAIL R11 watchdog got running expected halted");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    join_none

    // program 1: vector add through self-modified address fields (R12, R5, R4)
    clear_img();
    vec_data();
    img[0]  = ins(4'h1, 12'h040);  img[1]  = ins(4'h6, 12'd17);
    img[2]  = ins(4'h3, 12'h041);  img[3]  = ins(4'h2, 12'h040);
    img[4]  = ins(4'h1, 12'h050);  img[5]  = ins(4'h3, 12'h060);
    img[6]  = ins(4'h2, 12'h070);
    img[7]  = ins(4'h7, 12'd4);    img[8]  = ins(4'h3, 12'h041);  img[9]  = ins(4'h8, 12'd4);
    img[10] = ins(4'h7, 12'd5);    img[11] = ins(4'h3, 12'h041);  img[12] = ins(4'h8, 12'd5);
    img[13] = ins(4'h7, 12'd6);    img[14] = ins(4'h3, 12'h041);  img[15] = ins(4'h8, 12'd6);
    img[16] = ins(4'h5, 12'd0);    img[17] = ins(4'h0, 12'h000);
    run_prog("selfmod");
    chk("R12", "selfmod C0", 32'(mem[8'h70]), 32'h0007);
    chk("R12", "selfmod C1", 32'(mem[8'h71]), 32'h8001);
    chk("R12", "selfmod C2", 32'(mem[8'h72]), 32'h0001);
    chk("R4",  "selfmod count", 32'(mem[8'h40]), 32'h0000);
    chk("R5",  "selfmod field F1", 32'(mem[4]), 32'h1053);
    chk("R5",  "selfmod field F3", 32'(mem[6]), 32'h2073);

    // program 2: vector add through the index register (R12, R6, R7, R8)
    clear_img();
    vec_data();
    img[0] = ins(4'hD, 12'h040);  img[1] = ins(4'hC, 12'd6);
    img[2] = ins(4'h9, 12'h052);  img[3] = ins(4'hA, 12'h062);
    img[4] = ins(4'hB, 12'h072);  img[5] = ins(4'h5, 12'd1);
    img[6] = ins(4'h0, 12'h003);
    run_prog("indexed");
    chk("R12", "indexed C0", 32'(mem[8'h70]), 32'h0007);
    chk("R6",  "indexed C1", 32'(mem[8'h71]), 32'h8001);
    chk("R7",  "indexed C2", 32'(mem[8'h72]), 32'h0001);

    // program 3: single-instruction corner cases
    clear_img();
    img[8'h80] = 16'h1234;  img[8'h81] = 16'h0005;
    img[8'h82] = 16'hA00F;  img[8'h83] = 16'h8001;
    img[0]  = ins(4'h2, 12'h097);  img[1]  = ins(4'h1, 12'h080);
    img[2]  = ins(4'h4, 12'h081);  img[3]  = ins(4'h0, 12'h001);
    img[4]  = ins(4'h2, 12'h090);  img[5]  = ins(4'h1, 12'h083);
    img[6]  = ins(4'h0, 12'h002);  img[7]  = ins(4'h2, 12'h091);
    img[8]  = ins(4'h6, 12'h020);  img[9]  = ins(4'h7, 12'h082);
    img[10] = ins(4'h3, 12'h081);  img[11] = ins(4'h8, 12'h082);
    img[12] = ins(4'h6, 12'd15);   img[13] = ins(4'h2, 12'h092);
    img[14] = ins(4'h0, 12'h000);  img[15] = ins(4'hF, 12'hFFE);
    img[16] = ins(4'hE, 12'h093);  img[17] = ins(4'hF, 12'h003);
    img[18] = ins(4'hE, 12'h094);  img[19] = ins(4'h2, 12'h096);
    img[20] = ins(4'hC, 12'h030);  img[21] = ins(4'hE, 12'h095);
    img[22] = ins(4'h0, 12'h000);
    run_prog("corners");
    chk("R1",  "AC after reset", 32'(mem[8'h97]), 32'h0000);
    chk("R3",  "sub then shift left", 32'(mem[8'h90]), 32'h245E);
    chk("R10", "arith shift right", 32'(mem[8'h91]), 32'hC000);
    chk("R5",  "field store keeps opcode", 32'(mem[8'h82]), 32'hA014);
    chk("R4",  "branch skipped store", 32'(mem[8'h92]), 32'h0000);
    chk("R8",  "IX sign-extended", 32'(mem[8'h93]), 32'hFFFE);
    chk("R9",  "IX add immediate", 32'(mem[8'h94]), 32'h0001);
    chk("R9",  "AC kept by IX add", 32'(mem[8'h96]), 32'h0014);
    chk("R7",  "IX incremented on nonzero", 32'(mem[8'h95]), 32'h0002);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule